// File: doc/BRIEF.md
# Extender-side SPI slave with delayed readback

This block is the near-end SPI slave of a point-to-point bus extender. A local master drives SCK, MOSI and one of three active-low selects. The block oversamples those pins with its own clock and turns each received word into an entry of a transmit queue bound for the link. Transaction start and end events are placed in the same queue, so the far end can replay the selects in order.

Readback words come back from the link through a valid/ready input into a small receive FIFO. Each word is shifted out on MISO during the following word slot, so reads always trail by one word. The master must clock one extra dummy word to collect the last read. Word length is programmable from 8 to 32 bits. The slave serves SPI modes (0,0) and (1,1): MOSI is taken on SCK rising and MISO changes on SCK falling.

Top module: `spi_xlink_slave`

## Requirements
- R1: Each word of L bits is taken MSB first on SCK rising edges and is queued with kind 0 and the data right-aligned. L is the `word_len` value latched when a select falls, clamped to 8..32. The select index is 0, 1 or 2 for `ss_n[0]`, `ss_n[1]`, `ss_n[2]`.
- R2: When the selects leave the all-high state, a start event (kind 1, data 0) is queued. When they return to all-high, a stop event (kind 2, data 0) is queued. Both carry the select index, and events leave in the order they occurred.
- R3: A change of `word_len` during a transaction has no effect until the next transaction.
- R4: `miso_oe` is low while all selects are high. Within a transaction it stays low until the first full word has been received, and then it goes high.
- R5: During word k (k at least 1), MISO presents MSB first the low L bits of the readback word the link returned after word k-1. MISO changes only on SCK falling edges.
- R6: The receive FIFO is emptied when a transaction starts, so readback words queued before that moment never reach MISO.
- R7: If no readback word is present at a word boundary, `rx_underflow` pulses for one cycle and MISO holds its last driven value for the whole slot.
- R8: An event pushed while the transmit queue is full is dropped and `tx_overflow` pulses for one cycle. Entries already queued are kept in order.
- R9: Modes (0,0) and (1,1) give the same word and readback behaviour.
- R10: After reset, `tx_valid`, `miso_oe`, `tx_overflow` and `rx_underflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_len | input | 6 | Requested word length in bits |
| sck | input | 1 | SPI clock from the master |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 3 | Active-low selects |
| miso | output | 1 | Serial readback data |
| miso_oe | output | 1 | MISO driver enable |
| tx_valid | output | 1 | Transmit queue head valid |
| tx_ready | input | 1 | Link accepts the head entry |
| tx_kind | output | 2 | 0 data, 1 start, 2 stop |
| tx_sel | output | 2 | Select index of the entry |
| tx_data | output | 32 | Right-aligned word |
| rx_valid | input | 1 | Readback word offered |
| rx_ready | output | 1 | Receive FIFO has room |
| rx_data | input | 32 | Readback word, low L bits used |
| tx_overflow | output | 1 | Pulse: event dropped on full queue |
| rx_underflow | output | 1 | Pulse: no readback word at boundary |

## Verification
Random transactions vary the select, the mode, the word length and the word count. They check both the queued events and the bits the master reads back. A wrong shift direction, a wrong alignment or a wrong one-word offset shows up in those reads. Directed cases cover five situations: out-of-range lengths that must clamp, a length change in mid transaction, stale readback words that the start must discard, a slot with no readback word that must hold MISO steady, and a stalled link that must overflow the queue on exactly the expected events.

// File: rtl/spi_xlink_slave.sv
`timescale 1ns/1ps
module spi_xlink_slave #(
  parameter int MAX_LEN  = 32,
  parameter int MIN_LEN  = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int NSEL     = 3,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int SW = (NSEL > 1) ? $clog2(NSEL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LW-1:0]      word_len,
  input  logic               sck,
  input  logic               mosi,
  input  logic [NSEL-1:0]    ss_n,
  output logic               miso,
  output logic               miso_oe,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [1:0]         tx_kind,
  output logic [SW-1:0]      tx_sel,
  output logic [MAX_LEN-1:0] tx_data,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [MAX_LEN-1:0] rx_data,
  output logic               tx_overflow,
  output logic               rx_underflow
);
  localparam int TXW = 2 + SW + MAX_LEN;
  localparam int TPW = $clog2(TX_DEPTH);
  localparam int RPW = $clog2(RX_DEPTH);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  logic [2:0] sck_sy;
  logic [1:0] mosi_sy;
  logic [NSEL-1:0] ss_sy0, ss_s;
  logic act_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0; mosi_sy <= '0; ss_sy0 <= '1; ss_s <= '1; act_q <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[1:0], sck};
      mosi_sy <= {mosi_sy[0], mosi};
      ss_sy0 <= ss_n; ss_s <= ss_sy0;
      act_q <= ~&ss_s;
    end

  wire act   = ~&ss_s;
  wire start = act & ~act_q;
  wire stop  = ~act & act_q;
  wire live  = act & act_q;
  wire rise  = live & sck_sy[1] & ~sck_sy[2];
  wire fall  = live & ~sck_sy[1] & sck_sy[2];

  logic [SW-1:0] sel_c, sel_q;
  always_comb begin
    sel_c = '0;
    for (int i = NSEL - 1; i >= 0; i--) if (!ss_s[i]) sel_c = SW'(i);
  end

  wire [LW-1:0] len_c = (word_len < LW'(MIN_LEN)) ? LW'(MIN_LEN) :
                        (word_len > LW'(MAX_LEN)) ? LW'(MAX_LEN) : word_len;

  logic [LW-1:0] len_q, cnt;
  logic [MAX_LEN-1:0] shreg;
  wire [MAX_LEN-1:0] nxt = {shreg[MAX_LEN-2:0], mosi_sy[1]};
  wire done = rise & (cnt + LW'(1) == len_q);
  wire [MAX_LEN-1:0] wmask = {MAX_LEN{1'b1}} >> (LW'(MAX_LEN) - len_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len_q <= LW'(MIN_LEN); sel_q <= '0; cnt <= '0; shreg <= '0;
    end else if (start) begin
      len_q <= len_c; sel_q <= sel_c; cnt <= '0;
    end else if (rise) begin
      shreg <= nxt;
      cnt <= done ? '0 : cnt + LW'(1);
    end

  // transmit queue
  logic [TXW-1:0] tmem [TX_DEPTH];
  logic [TPW-1:0] twp, trp;
  logic [TCW-1:0] tcnt;
  wire tpush = start | stop | done;
  wire tfull = (tcnt == TCW'(TX_DEPTH));
  wire tpop  = tx_valid & tx_ready;
  wire twr   = tpush & ~tfull;
  wire [1:0] kind_in = start ? 2'd1 : stop ? 2'd2 : 2'd0;
  wire [MAX_LEN-1:0] data_in = done ? (nxt & wmask) : '0;

  always_ff @(posedge clk) if (twr) tmem[twp] <= {kind_in, start ? sel_c : sel_q, data_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0; tx_overflow <= 1'b0;
    end else begin
      tx_overflow <= tpush & tfull;
      if (twr) twp <= twp + TPW'(1);
      if (tpop) trp <= trp + TPW'(1);
      tcnt <= tcnt + TCW'(twr) - TCW'(tpop);
    end

  assign tx_valid = (tcnt != '0);
  assign {tx_kind, tx_sel, tx_data} = tmem[trp];

  // receive FIFO and MISO path
  logic [MAX_LEN-1:0] rmem [RX_DEPTH];
  logic [RPW-1:0] rwp, rrp;
  logic [RCW-1:0] rcnt;
  logic pending, hold, oe;
  logic [MAX_LEN-1:0] out_sh;
  wire load  = fall & pending;
  wire rpop  = load & (rcnt != '0);
  wire rpush = rx_valid & rx_ready & ~start;
  assign rx_ready = (rcnt != RCW'(RX_DEPTH));

  always_ff @(posedge clk) if (rpush) rmem[rwp] <= rx_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
      pending <= 1'b0; hold <= 1'b0; oe <= 1'b0; out_sh <= '0; rx_underflow <= 1'b0;
    end else begin
      rx_underflow <= load & (rcnt == '0);
      if (start) begin
        rwp <= '0; rrp <= '0; rcnt <= '0; pending <= 1'b0; hold <= 1'b0;
      end else begin
        if (rpush) rwp <= rwp + RPW'(1);
        if (rpop) rrp <= rrp + RPW'(1);
        rcnt <= rcnt + RCW'(rpush) - RCW'(rpop);
        if (done) begin pending <= 1'b1; oe <= 1'b1; end
        if (!act) begin oe <= 1'b0; pending <= 1'b0; end
        if (load) begin
          pending <= 1'b0;
          if (rpop) begin out_sh <= rmem[rrp] << (LW'(MAX_LEN) - len_q); hold <= 1'b0; end
          else hold <= 1'b1;
        end else if (fall && !hold) out_sh <= out_sh << 1;
      end
    end

  assign miso = out_sh[MAX_LEN-1];
  assign miso_oe = oe;
endmodule

// File: rtl/spi_xlink_slave_chk.sv
`timescale 1ns/1ps
module spi_xlink_slave_chk #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input logic clk, rst_n, act_q, start, stop, done, hold,
  input logic miso, miso_oe, tx_overflow, rx_underflow,
  input logic [TCW-1:0] tcnt,
  input logic [RCW-1:0] rcnt
);
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !act_q |-> !miso_oe); // R4
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({start, stop, done})); // R2
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n) tx_overflow |-> $past(tcnt) == TCW'(TX_DEPTH)); // R8
  AST_UNF_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) rx_underflow |-> $past(rcnt) == '0); // R7
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (hold && $past(hold)) |-> $stable(miso)); // R7
  AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) $past(start) |-> rcnt == '0); // R6
endmodule

bind spi_xlink_slave spi_xlink_slave_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_q(act_q), .start(start), .stop(stop), .done(done), .hold(hold),
  .miso(miso), .miso_oe(miso_oe), .tx_overflow(tx_overflow), .rx_underflow(rx_underflow),
  .tcnt(tcnt), .rcnt(rcnt)
);

// File: tb/sim_spi_xlink_slave.sv
`timescale 1ns/1ps
module sim_spi_xlink_slave;
  localparam int H = 8;
  logic clk = 0, rst_n = 0;
  logic [5:0] word_len = 6'd8;
  logic sck = 0, mosi = 0;
  logic [2:0] ss_n = 3'b111;
  logic miso, miso_oe, tx_valid, tx_ready = 1, rx_valid = 0, rx_ready;
  logic [1:0] tx_kind, tx_sel;
  logic [31:0] tx_data, rx_data = 0;
  logic tx_overflow, rx_underflow;

  spi_xlink_slave u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [1:0] exp_k [256];
  logic [1:0] exp_s [256];
  logic [31:0] exp_d [256];
  int exp_wr = 0, exp_rd = 0;
  bit resp_en = 1;
  int stale_n = 0, uf_cnt = 0, ov_cnt = 0;
  logic [31:0] sent [8], got [8];
  bit oe_first_ok, oe_after_ok;

  function automatic logic [31:0] resp(input logic [31:0] x);
    return x * 32'h9E37 + 32'h1234;
  endfunction
  function automatic logic [31:0] lmask(input int l);
    return (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 1);
  endfunction
  function automatic int clampl(input int l);
    return (l < 8) ? 8 : (l > 32) ? 32 : l;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual %h expected %h", req, act, exp); end
  endtask

  task automatic expect_ev(input logic [1:0] k, input logic [1:0] s, input logic [31:0] d);
    exp_k[exp_wr] = k; exp_s[exp_wr] = s; exp_d[exp_wr] = d; exp_wr++;
  endtask

  always @(negedge clk) begin
    rx_valid = 0;
    uf_cnt += int'(rx_underflow);
    ov_cnt += int'(tx_overflow);
    if (tx_valid && tx_ready) begin
      if (exp_rd < exp_wr) begin
        chk(tx_kind == exp_k[exp_rd] && tx_sel == exp_s[exp_rd] && tx_data == exp_d[exp_rd],
            "R1/R2 event", {tx_kind, tx_sel, tx_data[27:0]}, {exp_k[exp_rd], exp_s[exp_rd], exp_d[exp_rd][27:0]});
      end else chk(0, "R2 unexpected event", {30'd0, tx_kind}, 32'd0);
      exp_rd++;
      if (tx_kind == 2'd0 && resp_en) begin rx_valid = 1; rx_data = resp(tx_data); end
    end else if (stale_n > 0) begin
      rx_valid = 1; rx_data = 32'hDEAD_BEEF; stale_n--;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // mode3: 0 gives (0,0), 1 gives (1,1); alt_len != 0 changes word_len after word 0
  task automatic xfer(input int sel, input bit mode3, input int n, input int alt_len);
    oe_first_ok = 1; oe_after_ok = 1;
    for (int w = 0; w < 8; w++) got[w] = 0;
    sck = mode3; ss_n = 3'b111; ss_n[sel] = 1'b0;
    wait_clk(H);
    for (int w = 0; w < n; w++) begin
      if (w == 1 && alt_len != 0) word_len = 6'(alt_len);
      for (int b = 31; b >= 0; b--) begin
        if (b < clampl(int'(cur_len))) begin
          if (mode3) sck = 0;
          mosi = sent[w][b];
          wait_clk(H);
          got[w] = {got[w][30:0], miso};
          if (w == 0 && b == 0 && miso_oe) oe_first_ok = 0;
          if (w == 1 && !miso_oe) oe_after_ok = 0;
          sck = 1;
          wait_clk(H);
          if (!mode3) sck = 0;
        end
      end
    end
    wait_clk(H);
    ss_n = 3'b111;
    wait_clk(3 * H);
  endtask

  logic [5:0] cur_len;

  task automatic run(input int sel, input bit mode3, input int n, input int len, input int alt_len, input string tag);
    int l;
    l = clampl(len);
    word_len = 6'(len); cur_len = 6'(len);
    for (int w = 0; w < n; w++) sent[w] = $urandom;
    expect_ev(2'd1, 2'(sel), 32'd0);
    for (int w = 0; w < n; w++) expect_ev(2'd0, 2'(sel), sent[w] & lmask(l));
    expect_ev(2'd2, 2'(sel), 32'd0);
    xfer(sel, mode3, n, alt_len);
    chk(oe_first_ok, {tag, " R4 oe low in first word"}, 32'(!oe_first_ok), 32'd0);
    chk(oe_after_ok, {tag, " R4 oe high after first word"}, 32'(oe_after_ok), 32'd1);
    for (int w = 1; w < n; w++)
      chk((got[w] & lmask(l)) == (resp(sent[w-1]) & lmask(l)), {tag, " R5 one-word readback"},
          got[w] & lmask(l), resp(sent[w-1]) & lmask(l));
    chk(exp_rd == exp_wr, {tag, " R2 all events seen"}, 32'(exp_rd), 32'(exp_wr));
    chk(!miso_oe, {tag, " R4 oe low when idle"}, 32'(miso_oe), 32'd0);
  endtask

  bit finished = 0;
  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int l, u0c;
    void'($urandom(32'd2024));
    cur_len = 6'd8;
    wait_clk(4);
    chk(!tx_valid && !miso_oe && !tx_overflow && !rx_underflow, "R10 reset state",
        {28'd0, tx_valid, miso_oe, tx_overflow, rx_underflow}, 32'd0);
    rst_n = 1;
    wait_clk(4);

    // R1 R9 directed: both modes, boundary lengths
    run(0, 0, 3, 8, 0, "R1 R9 mode00 len8");
    run(1, 1, 3, 32, 0, "R1 R9 mode11 len32");
    // R1 clamping
    run(2, 0, 2, 5, 0, "R1 clamp low");
    run(0, 1, 2, 40, 0, "R1 clamp high");
    // R3 length change mid transaction
    run(1, 0, 3, 12, 20, "R3 len latch");
    // R6 stale readback words flushed at start
    stale_n = 2; wait_clk(10);
    run(2, 1, 3, 16, 0, "R6 flush");

    // R7 underflow: responder silent, mode (0,0), 3 words -> 3 empty boundaries
    resp_en = 0; u0c = uf_cnt;
    run(0, 0, 1, 8, 0, "R7 prime");
    u0c = uf_cnt;
    l = 10; word_len = 6'(l); cur_len = 6'(l);
    for (int w = 0; w < 3; w++) sent[w] = $urandom;
    expect_ev(2'd1, 2'd1, 0);
    for (int w = 0; w < 3; w++) expect_ev(2'd0, 2'd1, sent[w] & lmask(l));
    expect_ev(2'd2, 2'd1, 0);
    xfer(1, 0, 3, 0);
    chk(uf_cnt - u0c == 3, "R7 underflow pulses", 32'(uf_cnt - u0c), 32'd3);
    chk(((got[1] & lmask(l)) == (got[1][l-1] ? lmask(l) : 0)) &&
        ((got[2] & lmask(l)) == (got[1][l-1] ? lmask(l) : 0)), "R7 MISO held",
        got[2] & lmask(l), got[1][l-1] ? lmask(l) : 0);
    resp_en = 1;

    // R8 overflow: stalled link, start + 4 words + stop into 4 entries
    tx_ready = 0; resp_en = 0; ov_cnt = 0;
    l = 8; word_len = 6'(l); cur_len = 6'(l);
    for (int w = 0; w < 4; w++) sent[w] = $urandom;
    expect_ev(2'd1, 2'd2, 0);
    for (int w = 0; w < 3; w++) expect_ev(2'd0, 2'd2, sent[w] & lmask(l));
    xfer(2, 1, 4, 0);
    chk(ov_cnt == 2, "R8 overflow pulses", 32'(ov_cnt), 32'd2);
    tx_ready = 1; wait_clk(10);
    chk(exp_rd == exp_wr, "R8 kept entries drained", 32'(exp_rd), 32'(exp_wr));
    resp_en = 1;

    // random mix
    for (int t = 0; t < 12; t++) begin
      int sel, n, len;
      bit m;
      sel = int'($urandom_range(2, 0));
      m = 1'($urandom_range(1, 0));
      n = int'($urandom_range(4, 2));
      len = int'($urandom_range(32, 8));
      run(sel, m, n, len, 0, "R5 R9 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule